// File: doc/BRIEF.md
# Memory Map Store Checker

This block sits between a small microcontroller's store path and its data RAM port. A one-cycle pulse from the instruction decoder announces each store and carries its address and data byte. When the running domain is not the kernel and the address falls in the protected heap window, the block stalls the CPU. It takes over the RAM port to read the ownership entry for the 8-byte block being written. It commits the store only if the entry's owner matches the running domain. Otherwise it drops the store and pulses a fault.

Ownership entries are 4 bits wide. Bits [2:0] hold the owner ID and bit 3 is a segment-start flag. Two entries are packed per map byte: the low nibble covers the even block and the high nibble the odd block. The map byte for a store is `map_base + ((addr - prot_base) >> 4)`, and bit 3 of `(addr - prot_base)` selects the nibble. Owner ID 7 is the kernel.

Above the heap window lies the stack. There, a user store at or above the stack bound would reach into a caller's frame and is refused on the spot. A small bank of byte-wide configuration registers sets the window, the map location, the stack bound and the running domain. These registers sit at the top of the address space, and only the kernel may write them.

Top module: `mmap_store_guard`

## Requirements
- R1: After reset, `cpu_stall`, `fault` and `ram_we` are 0, and the running domain is the kernel (ID 7).
- R2: When no store is pending and no check is in progress, `ram_addr` follows `cpu_addr` and `ram_we` is 0.
- R3: A store issued while the kernel domain runs is written in the same cycle, to the same address, with no stall, even inside the protected window.
- R4: A user-domain store below `prot_base`, or at or above `prot_end` but below the stack bound, is written in the same cycle with no stall.
- R5: A user-domain store inside [`prot_base`, `prot_end`) raises `cpu_stall` for exactly two cycles. In the first of these cycles, `ram_addr` carries the map byte address with `ram_we` at 0.
- R6: If the selected owner nibble (bits [2:0]) equals the running domain, the third cycle writes the original address and data with `cpu_stall` low.
- R7: If the owner differs, no RAM write happens and `fault` pulses for one cycle in the third cycle. Address bit 3 (relative to `prot_base`) set selects the high nibble.
- R8: A user-domain store at an address at or above both `prot_end` and the stack bound is not written, and `fault` pulses in the store's own cycle.
- R9: Configuration bytes sit at `CFG_BASE` + offset. Offsets 0–1 hold `map_base`, 2–3 `prot_base`, 4–5 `prot_end` and 6–7 the stack bound, all little-endian. Offset 8 holds the domain ID. A kernel write updates the register. A user write is discarded and pulses `fault` in that cycle. Neither kind of write reaches RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | AW | CPU address for regular (non-store) RAM access |
| st_valid | input | 1 | One-cycle store pulse from the decoder |
| st_addr | input | AW | Store address |
| st_data | input | 8 | Store data |
| ram_rdata | input | 8 | Data RAM read data, one cycle after address |
| ram_addr | output | AW | Data RAM address |
| ram_we | output | 1 | Data RAM write enable |
| ram_wdata | output | 8 | Data RAM write data |
| cpu_stall | output | 1 | Holds the CPU while the map is consulted |
| fault | output | 1 | One-cycle pulse on a refused store or config write |

## Verification
A corrupted check state shows up at the ports within three cycles of the store pulse. It appears as a stall that lasts longer or shorter than two cycles, a write during a stall, or a commit and a fault in the same cycle. A wrong configuration register or domain ID shows up on the next checked store as a wrong map byte address on `ram_addr` in its first stall cycle. It can also appear as a refused store that should have passed, or the reverse. Nibble selection errors show up only on odd blocks, so the bench checks one even and one odd block that share a map byte.

// File: rtl/mmsg_pkg.sv
// Shared types and constants for the memory map store checker.
// Assumes byte-wide data RAM and 4-bit map entries packed two per byte.
package mmsg_pkg;

    localparam int          OWN_W     = 3;
    localparam logic [2:0]  KERNEL_ID = 3'd7;

    typedef struct packed {
        logic             seg_start;
        logic [OWN_W-1:0] owner;
    } map_entry_t;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_CMP  = 2'd1,
        CK_FIN  = 2'd2
    } chk_state_e;

    // Select the entry of a map byte: hi=1 picks the odd block's nibble.
    function automatic map_entry_t pick_entry(input logic [7:0] mbyte, input logic hi);
        return hi ? map_entry_t'(mbyte[7:4]) : map_entry_t'(mbyte[3:0]);
    endfunction

endpackage

// File: rtl/mmsg_cfg_regs.sv
// Byte-addressed configuration bank: map base, protected window, stack
// bound (each AW bits, little-endian bytes) and the running domain ID.
// Assumes wr_en arrives only when the controller is idle.
module mmsg_cfg_regs
    import mmsg_pkg::*;
#(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  MAP_RST   = '0,
    parameter logic [AW-1:0]  PBASE_RST = '0,
    parameter logic [AW-1:0]  PEND_RST  = '0,
    parameter logic [AW-1:0]  STK_RST   = '1,
    localparam int            BPR       = (AW + 7) / 8,
    localparam int            NUM       = 4 * BPR + 1,
    localparam int            OFF_W     = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [7:0]        wr_data,
    output logic              wr_reject,
    output logic [AW-1:0]     map_base,
    output logic [AW-1:0]     prot_base,
    output logic [AW-1:0]     prot_end,
    output logic [AW-1:0]     stack_bound,
    output logic [2:0]        dom_id
);

    localparam int RW = BPR * 8;
    localparam logic [4*RW-1:0] RST_PACK = {RW'(STK_RST), RW'(PEND_RST),
                                            RW'(PBASE_RST), RW'(MAP_RST)};

    logic [7:0]    cfg_q [NUM];
    logic [RW-1:0] reg_full [4];
    logic          kernel;

    assign kernel    = (cfg_q[NUM-1][2:0] == KERNEL_ID);
    assign wr_reject = wr_en && !kernel;

    // Register bank update: reset values, then kernel-only byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM - 1; i++) cfg_q[i] <= RST_PACK[i*8 +: 8];
            cfg_q[NUM-1] <= {5'd0, KERNEL_ID};
        end else if (wr_en && kernel && (int'(wr_off) < NUM)) begin
            cfg_q[wr_off] <= wr_data;
        end
    end

    // Gather byte lanes into full-width registers.
    always_comb begin
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < BPR; b++)
                reg_full[r][b*8 +: 8] = cfg_q[r*BPR + b];
    end

    assign map_base    = reg_full[0][AW-1:0];
    assign prot_base   = reg_full[1][AW-1:0];
    assign prot_end    = reg_full[2][AW-1:0];
    assign stack_bound = reg_full[3][AW-1:0];
    assign dom_id      = cfg_q[NUM-1][2:0];

endmodule

// File: rtl/mmsg_classify.sv
// Combinational store classifier: config hit, protected-window lookup
// need, stack bound violation, map byte address and nibble select.
// Assumes prot_base is 16-byte aligned so map bytes cover whole pairs.
module mmsg_classify
    import mmsg_pkg::*;
#(
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  CFG_BASE = '1,
    localparam int            BPR      = (AW + 7) / 8,
    localparam int            NUM      = 4 * BPR + 1,
    localparam int            OFF_W    = $clog2(NUM)
) (
    input  logic [AW-1:0]     st_addr,
    input  logic [AW-1:0]     map_base,
    input  logic [AW-1:0]     prot_base,
    input  logic [AW-1:0]     prot_end,
    input  logic [AW-1:0]     stack_bound,
    input  logic [2:0]        dom_id,
    output logic              is_cfg,
    output logic [OFF_W-1:0]  cfg_off,
    output logic              needs_lookup,
    output logic              stack_bad,
    output logic [AW-1:0]     map_addr,
    output logic              nib_hi
);

    logic [AW-1:0] cfg_rel;
    logic [AW-1:0] prot_rel;
    logic          kernel;
    logic          in_prot;

    // Decode config window and protected window membership.
    always_comb begin
        cfg_rel      = st_addr - CFG_BASE;
        is_cfg       = (st_addr >= CFG_BASE) && (cfg_rel < AW'(NUM));
        cfg_off      = cfg_rel[OFF_W-1:0];
        kernel       = (dom_id == KERNEL_ID);
        in_prot      = (st_addr >= prot_base) && (st_addr < prot_end);
        prot_rel     = st_addr - prot_base;
        map_addr     = map_base + (prot_rel >> 4);
        nib_hi       = prot_rel[3];
        needs_lookup = !kernel && in_prot;
        stack_bad    = !kernel && !in_prot && (st_addr >= prot_end)
                       && (st_addr >= stack_bound);
    end

endmodule

// File: rtl/mmsg_ctrl.sv
// Store check sequencer and RAM port multiplexer. Idle: RAM follows the
// CPU. A checked store takes three cycles: map read (stall), compare
// (stall), then commit or fault. Assumes a RAM with one-cycle read latency.
module mmsg_ctrl
    import mmsg_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [7:0]    st_data,
    input  logic          is_cfg,
    input  logic          needs_lookup,
    input  logic          stack_bad,
    input  logic [AW-1:0] map_addr,
    input  logic          nib_hi,
    input  logic [2:0]    dom_id,
    input  logic          cfg_reject,
    input  logic [7:0]    ram_rdata,
    output logic          cfg_wr_en,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [7:0]    ram_wdata,
    output logic          cpu_stall,
    output logic          fault
);

    chk_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] maddr_q;
    logic [7:0]    data_q;
    logic          hi_q;
    logic          ok_q;
    logic          start;
    logic          ok_d;
    map_entry_t    entry;

    assign start     = (state_q == CK_IDLE) && st_valid;
    assign cfg_wr_en = start && is_cfg;
    assign entry     = pick_entry(ram_rdata, hi_q);
    assign ok_d      = (entry.owner == dom_id);

    // Next state and RAM port steering.
    always_comb begin
        state_d   = state_q;
        ram_addr  = cpu_addr;
        ram_we    = 1'b0;
        ram_wdata = st_data;
        cpu_stall = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            CK_IDLE: begin
                if (start && is_cfg) begin
                    fault = cfg_reject;
                end else if (start && needs_lookup) begin
                    ram_addr  = map_addr;
                    cpu_stall = 1'b1;
                    state_d   = CK_CMP;
                end else if (start && stack_bad) begin
                    fault = 1'b1;
                end else if (start) begin
                    ram_addr = st_addr;
                    ram_we   = 1'b1;
                end
            end
            CK_CMP: begin
                ram_addr  = maddr_q;
                cpu_stall = 1'b1;
                state_d   = CK_FIN;
            end
            CK_FIN: begin
                if (ok_q) begin
                    ram_addr  = addr_q;
                    ram_we    = 1'b1;
                    ram_wdata = data_q;
                end else begin
                    fault = 1'b1;
                end
                state_d = CK_IDLE;
            end
            default: state_d = CK_IDLE;
        endcase
    end

    // State register and latched store operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            addr_q  <= '0;
            maddr_q <= '0;
            data_q  <= '0;
            hi_q    <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start && needs_lookup && !is_cfg) begin
                addr_q  <= st_addr;
                maddr_q <= map_addr;
                data_q  <= st_data;
                hi_q    <= nib_hi;
            end
            if (state_q == CK_CMP) ok_q <= ok_d;
        end
    end

endmodule

// File: rtl/mmap_store_guard.sv
// Top of the memory map store checker. Classifies each store, consults the
// ownership map in data RAM when needed and commits or refuses the write.
// Assumes the CPU holds off new stores while cpu_stall is high.
module mmap_store_guard
    import mmsg_pkg::*;
#(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  CFG_BASE  = 16'hFF00,
    parameter logic [AW-1:0]  MAP_RST   = '0,
    parameter logic [AW-1:0]  PBASE_RST = '0,
    parameter logic [AW-1:0]  PEND_RST  = '0,
    parameter logic [AW-1:0]  STK_RST   = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [7:0]    st_data,
    input  logic [7:0]    ram_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [7:0]    ram_wdata,
    output logic          cpu_stall,
    output logic          fault
);

    localparam int BPR   = (AW + 7) / 8;
    localparam int NUM   = 4 * BPR + 1;
    localparam int OFF_W = $clog2(NUM);

    logic [AW-1:0]    map_base, prot_base, prot_end, stack_bound, map_addr;
    logic [2:0]       dom_id;
    logic [OFF_W-1:0] cfg_off;
    logic             is_cfg, needs_lookup, stack_bad, nib_hi;
    logic             cfg_wr_en, cfg_reject;

    mmsg_cfg_regs #(
        .AW(AW), .MAP_RST(MAP_RST), .PBASE_RST(PBASE_RST),
        .PEND_RST(PEND_RST), .STK_RST(STK_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_off(cfg_off),
        .wr_data(st_data), .wr_reject(cfg_reject), .map_base(map_base),
        .prot_base(prot_base), .prot_end(prot_end),
        .stack_bound(stack_bound), .dom_id(dom_id)
    );

    mmsg_classify #(.AW(AW), .CFG_BASE(CFG_BASE)) u_cls (
        .st_addr(st_addr), .map_base(map_base), .prot_base(prot_base),
        .prot_end(prot_end), .stack_bound(stack_bound), .dom_id(dom_id),
        .is_cfg(is_cfg), .cfg_off(cfg_off), .needs_lookup(needs_lookup),
        .stack_bad(stack_bad), .map_addr(map_addr), .nib_hi(nib_hi)
    );

    mmsg_ctrl #(.AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .is_cfg(is_cfg),
        .needs_lookup(needs_lookup), .stack_bad(stack_bad),
        .map_addr(map_addr), .nib_hi(nib_hi), .dom_id(dom_id),
        .cfg_reject(cfg_reject), .ram_rdata(ram_rdata),
        .cfg_wr_en(cfg_wr_en), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .cpu_stall(cpu_stall), .fault(fault)
    );

endmodule

// File: rtl/mmsg_checker.sv
// Temporal properties of the store checker, observed at the top's ports.
module mmsg_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          ram_we,
    input logic          cpu_stall,
    input logic          fault
);

    // R7: a refused store never writes RAM in the same cycle
    p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !ram_we);

    // R5: the stall lasts no more than two cycles
    p_stall_two_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && $past(cpu_stall)) |-> !cpu_stall ##0 1'b1 or 1'b1 |=> !cpu_stall);

    // R5: the map read cycle carries no write
    p_map_read_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> !ram_we);

    // R6: a write without a store pulse is the commit that follows a stall
    p_commit_after_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !st_valid) |-> $past(cpu_stall));

    // R2: without a store or a pending check, RAM is never written
    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid && !$past(cpu_stall)) |-> !ram_we);

endmodule

bind mmap_store_guard mmsg_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .ram_we(ram_we),
    .cpu_stall(cpu_stall), .fault(fault)
);

// File: tb/mmap_store_guard_tb.sv
// Directed bench for the memory map store checker with a small RAM model.
module mmap_store_guard_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         AW         = 16;
    localparam logic [15:0] CFG       = 16'hFF00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [7:0]    st_data = '0;
    logic [7:0]    ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [7:0]    ram_wdata;
    logic          cpu_stall;
    logic          fault;

    logic [7:0] mem [4096];
    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmap_store_guard #(.AW(AW), .CFG_BASE(CFG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .cpu_stall(cpu_stall), .fault(fault)
    );

    // Synchronous RAM with one-cycle read latency.
    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr[11:0]] <= ram_wdata;
        ram_rdata <= mem[ram_addr[11:0]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a store pulse for one cycle; samples happen inside the window.
    task automatic put_store(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #2;
    endtask

    task automatic next_cycle();
        @(negedge clk);
        st_valid = 1'b0;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; st_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Kernel writes a config byte: no RAM write, no fault, no stall.
    task automatic cfg_write(input int off, input logic [7:0] d);
        put_store(CFG + 16'(off), d);
        check("R9 kernel cfg we", 32'(ram_we), 0);
        check("R9 kernel cfg fault", 32'(fault), 0);
        next_cycle();
    endtask

    task automatic t_reset();
        check("R1 stall", 32'(cpu_stall), 0);
        check("R1 fault", 32'(fault), 0);
        check("R1 we", 32'(ram_we), 0);
        cpu_addr = 16'h0123; #1;
        check("R2 addr follows cpu", 32'(ram_addr), 32'h0123);
    endtask

    // Map 0x0800, heap 0x0100..0x0200, stack bound 0x0F00; map byte 0x803=0x5A.
    task automatic t_configure();
        cfg_write(0, 8'h00); cfg_write(1, 8'h08);
        cfg_write(2, 8'h00); cfg_write(3, 8'h01);
        cfg_write(4, 8'h00); cfg_write(5, 8'h02);
        cfg_write(6, 8'h00); cfg_write(7, 8'h0F);
        put_store(16'h0803, 8'h5A);
        check("R3 kernel map store we", 32'(ram_we), 1);
        next_cycle();
        put_store(16'h0138, 8'h11);
        check("R3 kernel heap no stall", 32'(cpu_stall), 0);
        check("R3 kernel heap we", 32'(ram_we), 1);
        check("R3 kernel heap addr", 32'(ram_addr), 32'h0138);
        next_cycle();
        cfg_write(8, 8'h02);
    endtask

    task automatic t_match();
        put_store(16'h0130, 8'hAB);
        check("R5 stall c1", 32'(cpu_stall), 1);
        check("R5 map addr", 32'(ram_addr), 32'h0803);
        check("R5 no we c1", 32'(ram_we), 0);
        next_cycle();
        check("R5 stall c2", 32'(cpu_stall), 1);
        check("R5 no we c2", 32'(ram_we), 0);
        next_cycle();
        check("R6 stall dropped", 32'(cpu_stall), 0);
        check("R6 we", 32'(ram_we), 1);
        check("R6 addr", 32'(ram_addr), 32'h0130);
        check("R6 data", 32'(ram_wdata), 32'hAB);
        check("R6 no fault", 32'(fault), 0);
        next_cycle();
        check("R6 back to idle", 32'(cpu_stall), 0);
    endtask

    task automatic t_mismatch();
        put_store(16'h0138, 8'hCD);
        check("R7 stall c1", 32'(cpu_stall), 1);
        next_cycle();
        check("R7 no fault yet", 32'(fault), 0);
        next_cycle();
        check("R7 fault", 32'(fault), 1);
        check("R7 no we", 32'(ram_we), 0);
        next_cycle();
        check("R7 fault one cycle", 32'(fault), 0);
        check("R7 mem untouched", 32'(mem[12'h138]), 32'h11);
    endtask

    task automatic t_outside();
        put_store(16'h0300, 8'h33);
        check("R4 no stall", 32'(cpu_stall), 0);
        check("R4 we", 32'(ram_we), 1);
        check("R4 addr", 32'(ram_addr), 32'h0300);
        next_cycle();
        put_store(16'h0E00, 8'h44);
        check("R4 stack below bound we", 32'(ram_we), 1);
        check("R4 stack below bound fault", 32'(fault), 0);
        next_cycle();
    endtask

    task automatic t_stack();
        put_store(16'h0F10, 8'h55);
        check("R8 fault", 32'(fault), 1);
        check("R8 no we", 32'(ram_we), 0);
        check("R8 no stall", 32'(cpu_stall), 0);
        next_cycle();
        check("R8 fault one cycle", 32'(fault), 0);
    endtask

    task automatic t_cfg_user();
        put_store(CFG, 8'h40);
        check("R9 user cfg fault", 32'(fault), 1);
        check("R9 user cfg no we", 32'(ram_we), 0);
        next_cycle();
        put_store(16'h0130, 8'h66);
        check("R9 map base kept", 32'(ram_addr), 32'h0803);
        next_cycle(); next_cycle(); next_cycle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #2;
        t_reset();
        t_configure();
        t_match();
        t_mismatch();
        t_outside();
        t_stack();
        t_cfg_user();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule